// File: doc/BRIEF.md
# Register-Transfer Microoperation Datapath

This block holds three general registers (R0, R1, R2) on one free-running clock and applies one microoperation per cycle to them. An operation code selects a transfer, an arithmetic operation, a bitwise logic operation or a zero-fill shift. Two source selects choose the operands from the registers or from an external data input. A destination select chooses the register that receives the result. The write happens at the rising clock edge only while the control condition input is 1. A register that is not loaded takes its own output back through its feedback multiplexer, so the clock is never gated.

One condition flag, `sub_x`, turns a combined add/subtract operation into a subtraction by adding the ones complement of the second operand plus one. A separate two-variable transfer multiplexer copies R1 or R2 into R0, with `k1` ranking above `k2`. This multiplexer also ranks above any microoperation result aimed at R0. Arithmetic writes leave a carry flag and a zero flag behind.

Top module: `regxfer_dp`

## Requirements
- R1: When `cond_en`, `k1` and `k2` are all 0, no register and no flag changes at the clock edge, whatever the other inputs are.
- R2: Source select codes 0, 1, 2 and 3 pick R0, R1, R2 and `din`. Destination codes 0, 1 and 2 pick R0, R1 and R2. Operation code 0 copies operand A into the destination.
- R3: The arithmetic codes are 1 = A+B, 2 = ones complement of A, 3 = two's complement of A, 5 = A+1 and 6 = A−1. All of them wrap modulo 256.
- R4: Code 4 writes A + ~B + 1, which is A minus B. Its carry is 1 exactly when A ≥ B as unsigned numbers.
- R5: Code 13 writes A+B when `sub_x` = 0 and A + ~B + 1 when `sub_x` = 1. With `cond_en` = 0 the destination keeps its value.
- R6: The logic codes are 7 = NOT A, 8 = A OR B, 9 = A AND B and 10 = A XOR B. With A = 10101010 and B = 11110000 they give 01010101, 11111010, 10100000 and 01011010.
- R7: Code 11 shifts A left and code 12 shifts A right, and each puts a 0 into the vacated bit. With A = 11001001 they give 10010010 and 01100100.
- R8: Codes 14 and 15, and destination code 3, write no register and no flag.
- R9: Only an arithmetic write (codes 1 to 6 and 13) updates the flags. The carry becomes the bit-8 carry-out of the internal sum, which is 0 for code 2. The zero flag becomes 1 when the 8-bit result is 0. A logic or shift write leaves both flags unchanged.
- R10: When `k1` = 1, R0 takes the pre-edge R1 whatever `k2` is. When `k1` = 0 and `k2` = 1, R0 takes the pre-edge R2.
- R11: When the R0 multiplexer is active and a microoperation also targets R0 in the same cycle, the multiplexer value is written to R0.
- R12: A synchronous active-high `rst` clears R0, R1, R2, the carry flag and the zero flag to 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_sel | input | 4 | Microoperation code |
| dst_sel | input | 2 | Destination register select, 3 = none |
| src_a_sel | input | 2 | Operand A select |
| src_b_sel | input | 2 | Operand B select |
| din | input | 8 | External data operand |
| cond_en | input | 1 | Control condition gating the microoperation write |
| sub_x | input | 1 | Add (0) or subtract (1) for code 13 |
| k1 | input | 1 | R0 multiplexer: load R1 |
| k2 | input | 1 | R0 multiplexer: load R2 when k1 is 0 |
| r0_q | output | 8 | Register R0 |
| r1_q | output | 8 | Register R1 |
| r2_q | output | 8 | Register R2 |
| carry_q | output | 1 | Carry flag of the last arithmetic write |
| zero_q | output | 1 | Zero flag of the last arithmetic write |

## Verification
All state reaches the ports directly, so a wrong load enable, a wrong feedback path or a wrong operand shows up on the register outputs one clock edge after the operation that caused it. A missed flag update, or a flag update that should not have happened, shows up on `carry_q` and `zero_q` in that same cycle. A priority mistake in the R0 multiplexer shows up on `r0_q` in the cycle after the conflicting request. A fault inside the adder that only some operands reach is exposed by the corner values: wrap-around at 0xFF and 0x00, subtraction with equal operands, and the fixed logic and shift patterns.

// File: rtl/regxfer_pkg.sv
package regxfer_pkg;
    localparam int NREG = 3;
    localparam logic [1:0] DST_NONE = 2'd3;

    typedef enum logic [3:0] {
        OP_MOV    = 4'd0,
        OP_ADD    = 4'd1,
        OP_ONES   = 4'd2,
        OP_TWOS   = 4'd3,
        OP_SUB    = 4'd4,
        OP_INC    = 4'd5,
        OP_DEC    = 4'd6,
        OP_NOT    = 4'd7,
        OP_OR     = 4'd8,
        OP_AND    = 4'd9,
        OP_XOR    = 4'd10,
        OP_SHL    = 4'd11,
        OP_SHR    = 4'd12,
        OP_ADDSUB = 4'd13
    } op_e;
endpackage

// File: rtl/regxfer_arith.sv
module regxfer_arith import regxfer_pkg::*; #(
    parameter int W = 8
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub_x,
    output logic [W-1:0] res,
    output logic         carry,
    output logic         is_arith
);
    logic [W-1:0] x_in, y_in;
    logic         cin;

    // One adder serves every arithmetic code; the operands are steered into it
    always_comb begin
        x_in     = a;
        y_in     = '0;
        cin      = 1'b0;
        is_arith = 1'b1;
        case (op)
            OP_ADD:    y_in = b;
            OP_ONES:   x_in = ~a;
            OP_TWOS:   begin x_in = ~a; cin = 1'b1; end
            OP_SUB:    begin y_in = ~b; cin = 1'b1; end
            OP_INC:    cin = 1'b1;
            OP_DEC:    y_in = '1;
            OP_ADDSUB: begin y_in = sub_x ? ~b : b; cin = sub_x; end
            default:   is_arith = 1'b0;
        endcase
        {carry, res} = {1'b0, x_in} + {1'b0, y_in} + {{W{1'b0}}, cin};
    end
endmodule

// File: rtl/regxfer_logic.sv
module regxfer_logic import regxfer_pkg::*; #(
    parameter int W = 8
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         is_logic
);
    always_comb begin
        is_logic = 1'b1;
        res      = a;
        case (op)
            OP_MOV:  res = a;
            OP_NOT:  res = ~a;
            OP_OR:   res = a | b;
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            OP_SHL:  res = {a[W-2:0], 1'b0};
            OP_SHR:  res = {1'b0, a[W-1:1]};
            default: is_logic = 1'b0;
        endcase
    end
endmodule

// File: rtl/regxfer_dp.sv
module regxfer_dp import regxfer_pkg::*; #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [3:0]   op_sel,
    input  logic [1:0]   dst_sel,
    input  logic [1:0]   src_a_sel,
    input  logic [1:0]   src_b_sel,
    input  logic [W-1:0] din,
    input  logic         cond_en,
    input  logic         sub_x,
    input  logic         k1,
    input  logic         k2,
    output logic [W-1:0] r0_q,
    output logic [W-1:0] r1_q,
    output logic [W-1:0] r2_q,
    output logic         carry_q,
    output logic         zero_q
);
    typedef struct packed {
        logic [NREG-1:0][W-1:0] regs;
        logic                   carry;
        logic                   zero;
    } state_t;

    state_t st_d, st_q;

    logic [W-1:0] a_val, b_val, arith_res, logic_res, op_res;
    logic         arith_c, is_arith, is_logic, wr_ok;
    logic [NREG-1:0]        ld_en;
    logic [NREG-1:0][W-1:0] ld_val;

    // Operand selection: codes 0..2 pick a register, 3 picks the external input
    always_comb begin
        case (src_a_sel)
            2'd0:    a_val = st_q.regs[0];
            2'd1:    a_val = st_q.regs[1];
            2'd2:    a_val = st_q.regs[2];
            default: a_val = din;
        endcase
        case (src_b_sel)
            2'd0:    b_val = st_q.regs[0];
            2'd1:    b_val = st_q.regs[1];
            2'd2:    b_val = st_q.regs[2];
            default: b_val = din;
        endcase
    end

    regxfer_arith #(.W(W)) u_arith (
        .op       (op_sel),
        .a        (a_val),
        .b        (b_val),
        .sub_x    (sub_x),
        .res      (arith_res),
        .carry    (arith_c),
        .is_arith (is_arith)
    );

    regxfer_logic #(.W(W)) u_logic (
        .op       (op_sel),
        .a        (a_val),
        .b        (b_val),
        .res      (logic_res),
        .is_logic (is_logic)
    );

    assign op_res = is_arith ? arith_res : logic_res;
    assign wr_ok  = cond_en && (dst_sel != DST_NONE) && (is_arith || is_logic);

    // Per-register load enable and input value; R0 adds the two-variable transfer mux
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [1:0] IDX = 2'(i);
        if (i == 0) begin : g_r0
            assign ld_en[i]  = k1 || k2 || (wr_ok && (dst_sel == IDX));
            assign ld_val[i] = k1 ? st_q.regs[1] :
                               k2 ? st_q.regs[2] : op_res;
        end else begin : g_rn
            assign ld_en[i]  = wr_ok && (dst_sel == IDX);
            assign ld_val[i] = op_res;
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (ld_en[i]) st_d.regs[i] = ld_val[i];
        end
        if (wr_ok && is_arith) begin
            st_d.carry = arith_c;
            st_d.zero  = (arith_res == '0);
        end
        if (rst) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign r0_q    = st_q.regs[0];
    assign r1_q    = st_q.regs[1];
    assign r2_q    = st_q.regs[2];
    assign carry_q = st_q.carry;
    assign zero_q  = st_q.zero;
endmodule

// File: rtl/regxfer_chk.sv
module regxfer_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [3:0]   op_sel,
    input logic [1:0]   dst_sel,
    input logic [1:0]   src_a_sel,
    input logic [1:0]   src_b_sel,
    input logic [W-1:0] din,
    input logic         cond_en,
    input logic         k1,
    input logic         k2,
    input logic [W-1:0] r0_q,
    input logic [W-1:0] r1_q,
    input logic [W-1:0] r2_q,
    input logic         carry_q,
    input logic         zero_q
);
    logic [W-1:0] opa, opb;
    logic         arith_code;

    always_comb begin
        case (src_a_sel)
            2'd0: opa = r0_q;  2'd1: opa = r1_q;  2'd2: opa = r2_q;  default: opa = din;
        endcase
        case (src_b_sel)
            2'd0: opb = r0_q;  2'd1: opb = r1_q;  2'd2: opb = r2_q;  default: opb = din;
        endcase
        arith_code = ((op_sel >= 4'd1) && (op_sel <= 4'd6)) || (op_sel == 4'd13);
    end

    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        (!cond_en && !k1 && !k2) |=> ($stable(r0_q) && $stable(r1_q) && $stable(r2_q)
                                      && $stable(carry_q) && $stable(zero_q)));

    a_r8_unassigned: assert property (@(posedge clk) disable iff (rst)
        (cond_en && op_sel >= 4'd14 && !k1 && !k2) |=> ($stable(r0_q) && $stable(r1_q)
                                      && $stable(r2_q) && $stable(carry_q) && $stable(zero_q)));

    a_r10_k1_first: assert property (@(posedge clk) disable iff (rst)
        k1 |=> (r0_q == $past(r1_q)));

    a_r10_k2_second: assert property (@(posedge clk) disable iff (rst)
        (!k1 && k2) |=> (r0_q == $past(r2_q)));

    a_r3_add_to_r2: assert property (@(posedge clk) disable iff (rst)
        (cond_en && op_sel == 4'd1 && dst_sel == 2'd2) |=> (r2_q == $past(opa + opb)));

    a_r9_zero_flag: assert property (@(posedge clk) disable iff (rst)
        (cond_en && arith_code && dst_sel == 2'd2) |=> (zero_q == (r2_q == '0)));

    a_r7_shl_fill: assert property (@(posedge clk) disable iff (rst)
        (cond_en && op_sel == 4'd11 && dst_sel == 2'd1) |=> (r1_q[0] == 1'b0));
endmodule

bind regxfer_dp regxfer_chk #(.W(W)) u_regxfer_chk (
    .clk(clk), .rst(rst), .op_sel(op_sel), .dst_sel(dst_sel),
    .src_a_sel(src_a_sel), .src_b_sel(src_b_sel), .din(din),
    .cond_en(cond_en), .k1(k1), .k2(k2),
    .r0_q(r0_q), .r1_q(r1_q), .r2_q(r2_q),
    .carry_q(carry_q), .zero_q(zero_q)
);

// File: tb/test_regxfer_dp.sv
`timescale 1ns/1ps
module test_regxfer_dp;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_sel = '0;
    logic [1:0] dst_sel = 2'd3, src_a_sel = '0, src_b_sel = '0;
    logic [7:0] din = '0;
    logic       cond_en = 1'b0, sub_x = 1'b0, k1 = 1'b0, k2 = 1'b0;
    logic [7:0] r0_q, r1_q, r2_q;
    logic       carry_q, zero_q;

    int checks = 0;
    int fails  = 0;

    logic [7:0] m [3];
    logic       mc, mz;

    always #2.5 clk = ~clk;

    regxfer_dp i_regxfer_dp (
        .clk(clk), .rst(rst), .op_sel(op_sel), .dst_sel(dst_sel),
        .src_a_sel(src_a_sel), .src_b_sel(src_b_sel), .din(din),
        .cond_en(cond_en), .sub_x(sub_x), .k1(k1), .k2(k2),
        .r0_q(r0_q), .r1_q(r1_q), .r2_q(r2_q),
        .carry_q(carry_q), .zero_q(zero_q)
    );

    function automatic logic [7:0] srcv(input logic [1:0] s, input logic [7:0] d);
        if (s == 2'd3) return d;
        return m[s];
    endfunction

    // Expected results written from the requirement text, per operation code
    task automatic model(input logic [3:0] op, input logic [1:0] dst, input logic [1:0] sa,
                         input logic [1:0] sb, input logic x, input logic [7:0] d,
                         input logic cnd, input logic q1, input logic q2);
        logic [7:0] a, b, r, old1, old2;
        logic       c, ar, ok;
        a = srcv(sa, d); b = srcv(sb, d); old1 = m[1]; old2 = m[2];
        ar = 1'b1; ok = 1'b1; c = 1'b0; r = '0;
        case (op)
            4'd1:  begin r = a + b; c = (9'(a) + 9'(b)) > 9'd255; end
            4'd2:  begin r = ~a; c = 1'b0; end
            4'd3:  begin r = 8'd0 - a; c = (a == 8'd0); end
            4'd4:  begin r = a - b; c = (a >= b); end
            4'd5:  begin r = a + 8'd1; c = (a == 8'hFF); end
            4'd6:  begin r = a - 8'd1; c = (a != 8'd0); end
            4'd13: if (x) begin r = a - b; c = (a >= b); end
                   else begin r = a + b; c = (9'(a) + 9'(b)) > 9'd255; end
            default: begin
                ar = 1'b0;
                case (op)
                    4'd0:  r = a;
                    4'd7:  r = ~a;
                    4'd8:  r = a | b;
                    4'd9:  r = a & b;
                    4'd10: r = a ^ b;
                    4'd11: r = a << 1;
                    4'd12: r = a >> 1;
                    default: ok = 1'b0;
                endcase
            end
        endcase
        if (cnd && dst != 2'd3 && ok) begin
            m[dst] = r;
            if (ar) begin mc = c; mz = (r == 8'd0); end
        end
        if (q1) m[0] = old1;
        else if (q2) m[0] = old2;
    endtask

    task automatic compare(input string tag);
        checks++;
        if (r0_q !== m[0] || r1_q !== m[1] || r2_q !== m[2] || carry_q !== mc || zero_q !== mz) begin
            fails++;
            $display("FAIL %s: got r0=%h r1=%h r2=%h c=%b z=%b exp r0=%h r1=%h r2=%h c=%b z=%b",
                     tag, r0_q, r1_q, r2_q, carry_q, zero_q, m[0], m[1], m[2], mc, mz);
        end
    endtask

    task automatic lit(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b exp %b", tag, got, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge register, check at the next falling edge
    task automatic step(input string tag, input logic [3:0] op, input logic [1:0] dst,
                        input logic [1:0] sa, input logic [1:0] sb, input logic x,
                        input logic [7:0] d, input logic cnd, input logic q1, input logic q2);
        op_sel = op; dst_sel = dst; src_a_sel = sa; src_b_sel = sb; sub_x = x;
        din = d; cond_en = cnd; k1 = q1; k2 = q2;
        model(op, dst, sa, sb, x, d, cnd, q1, q2);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1; cond_en = 1'b0; k1 = 1'b0; k2 = 1'b0;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        m[0] = '0; m[1] = '0; m[2] = '0; mc = 1'b0; mz = 1'b0;
        compare("R12 reset");
    endtask

    task automatic t_transfer();
        step("R2 load R1", 4'd0, 2'd1, 2'd3, 2'd0, 0, 8'hAA, 1, 0, 0);
        step("R2 load R2", 4'd0, 2'd2, 2'd3, 2'd0, 0, 8'hF0, 1, 0, 0);
        step("R2 copy R1 to R0", 4'd0, 2'd0, 2'd1, 2'd0, 0, 8'h00, 1, 0, 0);
        lit("R2 copy value", r0_q, 8'hAA);
    endtask

    task automatic t_logic();
        step("R6 not", 4'd7, 2'd0, 2'd1, 2'd2, 0, 8'h00, 1, 0, 0);
        lit("R6 not value", r0_q, 8'b01010101);
        step("R6 or", 4'd8, 2'd0, 2'd1, 2'd2, 0, 8'h00, 1, 0, 0);
        lit("R6 or value", r0_q, 8'b11111010);
        step("R6 and", 4'd9, 2'd0, 2'd1, 2'd2, 0, 8'h00, 1, 0, 0);
        lit("R6 and value", r0_q, 8'b10100000);
        step("R6 xor", 4'd10, 2'd0, 2'd1, 2'd2, 0, 8'h00, 1, 0, 0);
        lit("R6 xor value", r0_q, 8'b01011010);
    endtask

    task automatic t_shift();
        step("R7 load", 4'd0, 2'd2, 2'd3, 2'd0, 0, 8'b11001001, 1, 0, 0);
        step("R7 shl", 4'd11, 2'd1, 2'd2, 2'd0, 0, 8'h00, 1, 0, 0);
        lit("R7 shl value", r1_q, 8'b10010010);
        step("R7 shr", 4'd12, 2'd1, 2'd2, 2'd0, 0, 8'h00, 1, 0, 0);
        lit("R7 shr value", r1_q, 8'b01100100);
    endtask

    task automatic t_arith();
        step("R3 add carry", 4'd1, 2'd0, 2'd3, 2'd2, 0, 8'h40, 1, 0, 0);
        step("R3 ones", 4'd2, 2'd0, 2'd3, 2'd0, 0, 8'h0F, 1, 0, 0);
        step("R3 twos", 4'd3, 2'd1, 2'd3, 2'd0, 0, 8'h01, 1, 0, 0);
        step("R3 twos of zero", 4'd3, 2'd1, 2'd3, 2'd0, 0, 8'h00, 1, 0, 0);
        step("R3 inc wrap", 4'd5, 2'd2, 2'd3, 2'd0, 0, 8'hFF, 1, 0, 0);
        lit("R3 inc wrap value", r2_q, 8'h00);
        step("R3 dec wrap", 4'd6, 2'd2, 2'd2, 2'd0, 0, 8'h00, 1, 0, 0);
        lit("R3 dec wrap value", r2_q, 8'hFF);
        step("R9 logic keeps flags", 4'd8, 2'd0, 2'd3, 2'd3, 0, 8'h00, 1, 0, 0);
        step("R9 zero flag on add", 4'd1, 2'd0, 2'd3, 2'd2, 0, 8'h01, 1, 0, 0);
    endtask

    task automatic t_sub();
        step("R4 set R1", 4'd0, 2'd1, 2'd3, 2'd0, 0, 8'h30, 1, 0, 0);
        step("R4 set R2", 4'd0, 2'd2, 2'd3, 2'd0, 0, 8'h50, 1, 0, 0);
        step("R4 R2 minus R1", 4'd4, 2'd0, 2'd2, 2'd1, 0, 8'h00, 1, 0, 0);
        lit("R4 difference", r0_q, 8'h20);
        step("R4 borrow", 4'd4, 2'd0, 2'd1, 2'd2, 0, 8'h00, 1, 0, 0);
        step("R4 equal", 4'd4, 2'd0, 2'd1, 2'd1, 0, 8'h00, 1, 0, 0);
    endtask

    task automatic t_addsub();
        step("R5 add", 4'd13, 2'd1, 2'd1, 2'd2, 0, 8'h00, 1, 0, 0);
        lit("R5 add value", r1_q, 8'h80);
        step("R5 sub", 4'd13, 2'd1, 2'd1, 2'd2, 1, 8'h00, 1, 0, 0);
        lit("R5 sub value", r1_q, 8'h30);
        step("R5 condition off", 4'd13, 2'd1, 2'd1, 2'd2, 0, 8'h00, 0, 0, 0);
    endtask

    task automatic t_hold();
        step("R1 hold add", 4'd1, 2'd2, 2'd3, 2'd3, 0, 8'h77, 0, 0, 0);
        step("R1 hold move", 4'd0, 2'd0, 2'd3, 2'd0, 0, 8'h11, 0, 0, 0);
        step("R8 code 14", 4'd14, 2'd0, 2'd3, 2'd3, 0, 8'h99, 1, 0, 0);
        step("R8 code 15", 4'd15, 2'd2, 2'd3, 2'd3, 0, 8'h99, 1, 0, 0);
        step("R8 no destination", 4'd1, 2'd3, 2'd3, 2'd3, 0, 8'h99, 1, 0, 0);
    endtask

    task automatic t_mux();
        step("R10 set R1", 4'd0, 2'd1, 2'd3, 2'd0, 0, 8'h5C, 1, 0, 0);
        step("R10 set R2", 4'd0, 2'd2, 2'd3, 2'd0, 0, 8'hC3, 1, 0, 0);
        step("R10 k2 only", 4'd0, 2'd0, 2'd0, 2'd0, 0, 8'h00, 0, 0, 1);
        lit("R10 k2 value", r0_q, 8'hC3);
        step("R10 k1 and k2", 4'd0, 2'd0, 2'd0, 2'd0, 0, 8'h00, 0, 1, 1);
        lit("R10 k1 value", r0_q, 8'h5C);
        step("R10 R1 swapped same edge", 4'd0, 2'd1, 2'd3, 2'd0, 0, 8'h01, 1, 1, 0);
        lit("R10 pre-edge R1", r0_q, 8'h5C);
        step("R11 mux beats microop", 4'd0, 2'd0, 2'd3, 2'd0, 0, 8'hEE, 1, 0, 1);
        lit("R11 value", r0_q, 8'hC3);
        step("R11 mux with other dest", 4'd0, 2'd2, 2'd3, 2'd0, 0, 8'h3A, 1, 1, 0);
    endtask

    task automatic run_all();
        repeat (2) @(negedge clk);
        do_reset();
        t_transfer();
        t_logic();
        t_shift();
        t_arith();
        t_sub();
        t_addsub();
        t_hold();
        t_mux();
        do_reset();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: got timeout exp completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule